// File: doc/BRIEF.md
# FIFO-Level DMA Request Generator

This block turns the fill level of a byte FIFO in a card data path into a DMA request line. Software writes one 8-bit control register over a small address/strobe bus. The register holds an enable bit, an auto-transfer bit and a 3-bit condition code. The condition code chooses one of eight request rules.

The rules fall into three groups. Some fire when the FIFO is at or below a fraction of its capacity, which suits refilling during card writes. Some fire when it is at or above a fraction, which suits draining during card reads. One rule fires whenever any byte is present. The fractions are a quarter, a half and three quarters of a power-of-two capacity, and every comparison includes its threshold.

The auto-transfer bit is also checked against an open-ended transfer input. If the bit is set during an open-ended transfer, the block withholds auto mode and raises an error flag. All outputs are registered.

Top module: `dmareq_gen`

## Requirements
- R1: After reset the register reads 0x00, and `dma_req`, `auto_active` and `auto_err` are all 0.
- R2: A write with `cfg_we` high and `cfg_addr` equal to `REG_ADDR` updates the register. `cfg_rdata` shows the value at `REG_ADDR` one clock after the address is presented, and shows 0 at any other address. Writes to other addresses leave the register unchanged.
- R3: Register layout: bit 7 is the enable, bit 6 is auto mode and bits 2..0 are the condition code. Bits 5..3 always read 0, whatever value is written to them.
- R4: While the enable bit is 0, `dma_req` stays 0 at every FIFO level and for every code.
- R5: Code 000 never asserts `dma_req`.
- R6: Codes 001, 010 and 011 assert `dma_req` when `fifo_count` is at or below DEPTH/4, DEPTH/2 and DEPTH-DEPTH/4 respectively.
- R7: Code 100 asserts `dma_req` when `fifo_count` is 1 or more.
- R8: Codes 101, 110 and 111 assert `dma_req` when `fifo_count` is at or above DEPTH/4, DEPTH/2 and DEPTH-DEPTH/4 respectively.
- R9: `dma_req` is registered. It follows a change of `fifo_count` or of the register one clock later, not in the same cycle.
- R10: `auto_active` is 1 one clock after the auto bit is 1 while `open_ended` is 0. Otherwise it is 0.
- R11: `auto_err` is 1 one clock after the auto bit is 1 while `open_ended` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | ADDR_W | Register bus address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| fifo_count | input | $clog2(DEPTH)+1 | Bytes currently held in the FIFO |
| open_ended | input | 1 | High while the current multiblock transfer has no preset length |
| dma_req | output | 1 | DMA request |
| auto_active | output | 1 | Auto mode in effect |
| auto_err | output | 1 | Auto mode requested during an open-ended transfer |

## Verification
Two functions can act in the same cycle: a register write that changes the code or the enable, and a change of the FIFO count. The bench provokes this by writing a new code in one cycle and moving the count in the next. It then checks that `dma_req` follows the reference rule for the new code and the new count exactly one clock later, and that the old value still holds just after the inputs move. The auto guard is judged the same way: the auto bit is held while `open_ended` toggles, and `auto_active` and `auto_err` must swap within one clock and never be high together.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
  // Register field positions (software-visible layout)
  localparam int EN_BIT   = 7;
  localparam int AUTO_BIT = 6;
  localparam int CODE_LSB = 0;
  localparam logic [7:0] WR_MASK = 8'hC7;

  typedef enum logic [2:0] {
    COND_NONE  = 3'd0,
    COND_LE_Q  = 3'd1,
    COND_LE_H  = 3'd2,
    COND_LE_TQ = 3'd3,
    COND_ANY   = 3'd4,
    COND_GE_Q  = 3'd5,
    COND_GE_H  = 3'd6,
    COND_GE_TQ = 3'd7
  } req_cond_e;
endpackage

// File: rtl/dmareq_cfg_reg.sv
module dmareq_cfg_reg #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              en,
  output logic              auto_bit,
  output dmareq_pkg::req_cond_e code
);
  import dmareq_pkg::*;

  logic [7:0] ctl_q;
  logic       hit_addr;

  assign hit_addr = (cfg_addr == REG_ADDR);

  // Reserved bits are masked on write, so they hold 0 forever
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= 8'h00;
    end else if (cfg_we && hit_addr) begin
      ctl_q <= cfg_wdata & WR_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= 8'h00;
    end else begin
      cfg_rdata <= hit_addr ? ctl_q : 8'h00;
    end
  end

  assign en       = ctl_q[EN_BIT];
  assign auto_bit = ctl_q[AUTO_BIT];
  assign code     = req_cond_e'(ctl_q[CODE_LSB +: 3]);
endmodule

// File: rtl/dmareq_level_cmp.sv
module dmareq_level_cmp #(
  parameter int DEPTH = 512,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  dmareq_pkg::req_cond_e code,
  input  logic [CNT_W-1:0]     fifo_count,
  output logic                 dma_req
);
  import dmareq_pkg::*;

  // DEPTH must be a power of two and at least 4
  localparam logic [CNT_W-1:0] TH_Q  = CNT_W'(DEPTH >> 2);
  localparam logic [CNT_W-1:0] TH_H  = CNT_W'(DEPTH >> 1);
  localparam logic [CNT_W-1:0] TH_TQ = CNT_W'(DEPTH - (DEPTH >> 2));

  logic [CNT_W-1:0] th [3];
  logic [7:0]       hit;
  logic             req_d;

  assign th[0] = TH_Q;
  assign th[1] = TH_H;
  assign th[2] = TH_TQ;

  assign hit[COND_NONE] = 1'b0;
  assign hit[COND_ANY]  = (fifo_count != '0);

  // Fraction rules: low group refills, high group drains
  for (genvar i = 0; i < 3; i++) begin : g_frac
    assign hit[1 + i] = (fifo_count <= th[i]);
    assign hit[5 + i] = (fifo_count >= th[i]);
  end

  assign req_d = en & hit[code];

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= req_d;
  end
endmodule

// File: rtl/dmareq_auto_guard.sv
module dmareq_auto_guard (
  input  logic clk,
  input  logic rst,
  input  logic auto_bit,
  input  logic open_ended,
  output logic auto_active,
  output logic auto_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      auto_active <= 1'b0;
      auto_err    <= 1'b0;
    end else begin
      auto_active <= auto_bit & ~open_ended;
      auto_err    <= auto_bit &  open_ended;
    end
  end
endmodule

// File: rtl/dmareq_gen.sv
module dmareq_gen #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(3),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              open_ended,
  output logic              dma_req,
  output logic              auto_active,
  output logic              auto_err
);
  import dmareq_pkg::*;

  logic      cfg_en;
  logic      cfg_auto;
  req_cond_e cfg_code;

  dmareq_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .en(cfg_en), .auto_bit(cfg_auto), .code(cfg_code)
  );

  dmareq_level_cmp #(.DEPTH(DEPTH)) u_cmp (
    .clk(clk), .rst(rst), .en(cfg_en), .code(cfg_code),
    .fifo_count(fifo_count), .dma_req(dma_req)
  );

  dmareq_auto_guard u_auto (
    .clk(clk), .rst(rst), .auto_bit(cfg_auto), .open_ended(open_ended),
    .auto_active(auto_active), .auto_err(auto_err)
  );
endmodule

// File: rtl/dmareq_gen_chk.sv
module dmareq_gen_chk #(
  parameter int DEPTH = 512,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_en,
  input logic             reg_auto,
  input logic [2:0]       reg_code,
  input logic [CNT_W-1:0] fifo_count,
  input logic             open_ended,
  input logic             dma_req,
  input logic             auto_active,
  input logic             auto_err,
  input logic [7:0]       cfg_rdata
);
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[5:3] == 3'b000);

  p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !reg_en |=> !dma_req);

  p_none_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_code == 3'd0) |=> !dma_req);

  p_low_full_r6: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == CNT_W'(DEPTH) && reg_code >= 3'd1 && reg_code <= 3'd3) |=> !dma_req);

  p_empty_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == '0 && reg_code >= 3'd4) |=> !dma_req);

  p_auto_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    open_ended |=> !auto_active);

  p_auto_err_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_auto && open_ended) |=> auto_err);
endmodule

bind dmareq_gen dmareq_gen_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .reg_en(cfg_en), .reg_auto(cfg_auto),
  .reg_code(cfg_code), .fifo_count(fifo_count), .open_ended(open_ended),
  .dma_req(dma_req), .auto_active(auto_active), .auto_err(auto_err),
  .cfg_rdata(cfg_rdata)
);

// File: tb/dmareq_gen_bench.sv
module dmareq_gen_bench;
  localparam int DEPTH  = 512;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] RADDR = 4'd3;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic              cfg_we = 1'b0;
  logic [7:0]        cfg_wdata = '0;
  logic [7:0]        cfg_rdata;
  logic [CNT_W-1:0]  fifo_count = '0;
  logic              open_ended = 1'b0;
  logic              dma_req, auto_active, auto_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  dmareq_gen #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .REG_ADDR(RADDR)) u_dmareq_gen (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fifo_count(fifo_count),
    .open_ended(open_ended), .dma_req(dma_req),
    .auto_active(auto_active), .auto_err(auto_err)
  );

  function automatic bit ref_req(bit en, int code, int cnt);
    int q, h, tq;
    q = DEPTH / 4; h = DEPTH / 2; tq = DEPTH - DEPTH / 4;
    if (!en) return 1'b0;
    case (code)
      1: return cnt <= q;
      2: return cnt <= h;
      3: return cnt <= tq;
      4: return cnt >= 1;
      5: return cnt >= q;
      6: return cnt >= h;
      7: return cnt >= tq;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = RADDR;
  endtask

  task automatic rd_check(string req, logic [ADDR_W-1:0] a, logic [7:0] exp);
    cfg_addr = a;
    @(negedge clk);
    check(req, cfg_rdata, exp);
    cfg_addr = RADDR;
  endtask

  task automatic t_reset;
    check("R1 rdata", cfg_rdata, 8'h00);
    check("R1 dma_req", dma_req, 0);
    check("R1 auto_active", auto_active, 0);
    check("R1 auto_err", auto_err, 0);
  endtask

  task automatic t_regs;
    rd_check("R1 reg after reset", RADDR, 8'h00);
    wr(RADDR + 4'd1, 8'hFF);
    rd_check("R2 other-address write ignored", RADDR, 8'h00);
    wr(RADDR, 8'hFF);
    rd_check("R3 reserved bits read 0", RADDR, 8'hC7);
    rd_check("R2 other address reads 0", RADDR + 4'd1, 8'h00);
    wr(RADDR, 8'h85);
    rd_check("R2 readback", RADDR, 8'h85);
    wr(RADDR, 8'h00);
  endtask

  task automatic t_sweep(bit en);
    for (int code = 0; code < 8; code++) begin
      wr(RADDR, {en, 1'b0, 3'b000, 3'(code)});
      for (int c = 0; c <= DEPTH; c++) begin
        fifo_count = CNT_W'(c);
        @(negedge clk);
        if (!en)            check("R4 disabled", dma_req, 0);
        else if (code == 0) check("R5 code none", dma_req, 0);
        else if (code < 4)  check("R6 at-or-below", dma_req, ref_req(en, code, c));
        else if (code == 4) check("R7 any byte", dma_req, ref_req(en, code, c));
        else                check("R8 at-or-above", dma_req, ref_req(en, code, c));
      end
    end
  endtask

  task automatic t_timing;
    fifo_count = CNT_W'(DEPTH / 2);
    wr(RADDR, 8'h86);            // en, code 110
    @(negedge clk);
    check("R9 settled", dma_req, 1);
    fifo_count = CNT_W'(DEPTH / 2 - 1);
    #1 check("R9 count change not yet seen", dma_req, 1);
    @(negedge clk);
    check("R9 count change after one clock", dma_req, 0);
    cfg_addr = RADDR; cfg_wdata = 8'h82; cfg_we = 1'b1; // code 010
    #1 check("R9 before write edge", dma_req, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    fifo_count = CNT_W'(DEPTH / 2 + 1);
    @(negedge clk);
    check("R9 write and count together", dma_req, ref_req(1, 2, DEPTH / 2 + 1));
    fifo_count = CNT_W'(DEPTH / 2);
    @(negedge clk);
    check("R6 half boundary inclusive", dma_req, 1);
  endtask

  task automatic t_auto;
    open_ended = 1'b0;
    wr(RADDR, 8'h40);
    @(negedge clk);
    check("R10 auto active", auto_active, 1);
    check("R11 no error", auto_err, 0);
    open_ended = 1'b1;
    #1 check("R10 registered", auto_active, 1);
    @(negedge clk);
    check("R10 suppressed when open-ended", auto_active, 0);
    check("R11 error when open-ended", auto_err, 1);
    wr(RADDR, 8'h00);
    @(negedge clk);
    check("R11 error clears with auto off", auto_err, 0);
    check("R10 inactive with auto off", auto_active, 0);
    open_ended = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cfg_addr = RADDR;
    @(negedge clk);
    t_reset();
    t_regs();
    t_sweep(1'b1);
    t_sweep(1'b0);
    t_timing();
    t_auto();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule